// File: doc/BRIEF.md
# Asynchronous External Memory Strobe Sequencer

This block produces the control strobes for one chip select of an asynchronous external memory port: chip select, address valid, output enable and write enable. All four are active low. Every edge is placed at a programmed count of functional-clock ticks. Software writes four timing words through a small register port. Each word holds assert and deassert ticks, and the deassert ticks are separate for reads and for writes.

A requester raises `req_valid` together with `req_write`. The request is accepted when `req_ready` is high. The sequencer then leaves `ST_IDLE` for `ST_RUN` (transition LAUNCH) and counts ticks from zero. While it counts, it drives each strobe over its programmed window and pulses `rd_capture` on the read data sampling tick. It returns to `ST_IDLE` on the last tick of the programmed cycle length (transition FINISH). Within `ST_RUN` the counter only advances (transition STEP).

The timing is captured at acceptance. Writes to the registers in the middle of a cycle therefore only shape later cycles. All strobe outputs are registered, so they cannot glitch.

Top module: `emc_strobe_seq`

## Requirements
- R1: After reset, all four strobes are high, `rd_capture` and `busy` are low, `req_ready` is high, and every timing word reads back as zero.
- R2: The timing words are selected by `cfg_idx`. Index 0 is chip select and index 1 is address valid: both hold the assert tick in [3:0], the read deassert tick in [12:8] and the write deassert tick in [20:16]. Index 2 holds the output-enable assert tick in [3:0] and its deassert tick in [12:8], plus the write-enable assert tick in [19:16] and its deassert tick in [28:24]. Index 3 holds the read cycle length in [4:0], the write cycle length in [12:8], the read sampling tick in [20:16] and a page access time in [27:24]. Bits outside these fields read as zero.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The tick counter is 0 in the clock that follows. The read or write type is taken from `req_write` at acceptance.
- R4: `cs_n` and `adv_n` are low exactly on ticks t where assert <= t < deassert. The deassert value is the read value for reads and the write value for writes.
- R5: `oe_n` is low on ticks where oe assert <= t < oe deassert, during reads only. `we_n` is low on ticks where we assert <= t < we deassert, during writes only.
- R6: In a read cycle, `rd_capture` is high for exactly the tick equal to the sampling tick. It never pulses in a write cycle, and never pulses when the sampling tick is not below the cycle length.
- R7: A cycle lasts the read or write cycle length in ticks, and a length of 0 acts as 1. `busy` is high on exactly those ticks. After the last tick, the block is idle with all strobes high.
- R8: `req_ready` is low throughout a cycle. A request held across a cycle is accepted on the first idle clock, leaving exactly one idle tick between the two cycles.
- R9: Timing words written while a cycle runs do not change that cycle. They apply from the next accepted cycle.
- R10: A strobe whose assert tick is not below its deassert tick stays high for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock; one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the timing word at `cfg_idx` |
| cfg_idx | input | 2 | Timing word index |
| cfg_wdata | input | 32 | Timing word write data |
| cfg_rdata | output | 32 | Timing word read data (combinational) |
| req_valid | input | 1 | Cycle request |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_ready | output | 1 | High when a request can be accepted |
| busy | output | 1 | High during every tick of a running cycle |
| cs_n | output | 1 | Chip select, active low |
| adv_n | output | 1 | Address valid, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| rd_capture | output | 1 | One-tick pulse marking the read data sampling tick |

## Verification
The assertions check the following on every cycle:
- the launch into `ST_RUN` with the counter at zero;
- that the counter never passes the last tick;
- that the captured timing stays frozen inside a cycle;
- that output enable and write enable never cross into the wrong cycle type;
- that everything is quiet while idle.

Only the bench scenarios can show that each strobe window lands on the exact programmed ticks. The same holds for read versus write deassert selection, the zero-length and out-of-range sampling corners, and a held request restarting after exactly one idle tick. A mid-cycle register write that changes only the following cycle is likewise shown only by a scenario.

// File: rtl/emc_strobe_pkg.sv
package emc_strobe_pkg;

    localparam int WORD_W      = 32;
    localparam int IDX_W       = 2;
    localparam int ON_W        = 4;
    localparam int OFF_W       = 5;
    localparam int CNT_W       = OFF_W;
    localparam int PAGE_W      = 4;
    localparam int NUM_STROBES = 4;

    // field placement inside the timing words
    localparam int F_ON_LSB     = 0;
    localparam int F_RD_LSB     = 8;
    localparam int F_WR_LSB     = 16;
    localparam int F_WE_OFF_LSB = 24;
    localparam int F_PAGE_LSB   = 24;

    // strobe slots
    localparam int STB_CS  = 0;
    localparam int STB_ADV = 1;
    localparam int STB_OE  = 2;
    localparam int STB_WE  = 3;

    typedef enum logic [IDX_W-1:0] {
        W_CHIPSEL = 2'd0,
        W_ADDRVAL = 2'd1,
        W_ENABLES = 2'd2,
        W_CYCLE   = 2'd3
    } word_idx_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [ON_W-1:0]   cs_on;
        logic [OFF_W-1:0]  cs_rd_off;
        logic [OFF_W-1:0]  cs_wr_off;
        logic [ON_W-1:0]   adv_on;
        logic [OFF_W-1:0]  adv_rd_off;
        logic [OFF_W-1:0]  adv_wr_off;
        logic [ON_W-1:0]   oe_on;
        logic [OFF_W-1:0]  oe_off;
        logic [ON_W-1:0]   we_on;
        logic [OFF_W-1:0]  we_off;
        logic [CNT_W-1:0]  rd_len;
        logic [CNT_W-1:0]  wr_len;
        logic [CNT_W-1:0]  sample;
        logic [PAGE_W-1:0] page;
    } timing_cfg_t;

    typedef struct packed {
        logic                                   write;
        logic [NUM_STROBES-1:0][CNT_W-1:0]      on_tick;
        logic [NUM_STROBES-1:0][CNT_W-1:0]      off_tick;
        logic [CNT_W-1:0]                       sample;
        logic [CNT_W-1:0]                       last_tick;
    } cycle_cfg_t;

endpackage

// File: rtl/emc_timing_regs.sv
module emc_timing_regs
    import emc_strobe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output timing_cfg_t       cfg
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (word_idx_e'(idx))
                W_CHIPSEL: begin
                    cfg.cs_on     <= wdata[F_ON_LSB +: ON_W];
                    cfg.cs_rd_off <= wdata[F_RD_LSB +: OFF_W];
                    cfg.cs_wr_off <= wdata[F_WR_LSB +: OFF_W];
                end
                W_ADDRVAL: begin
                    cfg.adv_on     <= wdata[F_ON_LSB +: ON_W];
                    cfg.adv_rd_off <= wdata[F_RD_LSB +: OFF_W];
                    cfg.adv_wr_off <= wdata[F_WR_LSB +: OFF_W];
                end
                W_ENABLES: begin
                    cfg.oe_on  <= wdata[F_ON_LSB +: ON_W];
                    cfg.oe_off <= wdata[F_RD_LSB +: OFF_W];
                    cfg.we_on  <= wdata[F_WR_LSB +: ON_W];
                    cfg.we_off <= wdata[F_WE_OFF_LSB +: OFF_W];
                end
                default: begin
                    cfg.rd_len <= wdata[F_ON_LSB +: CNT_W];
                    cfg.wr_len <= wdata[F_RD_LSB +: CNT_W];
                    cfg.sample <= wdata[F_WR_LSB +: CNT_W];
                    cfg.page   <= wdata[F_PAGE_LSB +: PAGE_W];
                end
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (word_idx_e'(idx))
            W_CHIPSEL: begin
                rdata[F_ON_LSB +: ON_W]  = cfg.cs_on;
                rdata[F_RD_LSB +: OFF_W] = cfg.cs_rd_off;
                rdata[F_WR_LSB +: OFF_W] = cfg.cs_wr_off;
            end
            W_ADDRVAL: begin
                rdata[F_ON_LSB +: ON_W]  = cfg.adv_on;
                rdata[F_RD_LSB +: OFF_W] = cfg.adv_rd_off;
                rdata[F_WR_LSB +: OFF_W] = cfg.adv_wr_off;
            end
            W_ENABLES: begin
                rdata[F_ON_LSB +: ON_W]      = cfg.oe_on;
                rdata[F_RD_LSB +: OFF_W]     = cfg.oe_off;
                rdata[F_WR_LSB +: ON_W]      = cfg.we_on;
                rdata[F_WE_OFF_LSB +: OFF_W] = cfg.we_off;
            end
            default: begin
                rdata[F_ON_LSB +: CNT_W]    = cfg.rd_len;
                rdata[F_RD_LSB +: CNT_W]    = cfg.wr_len;
                rdata[F_WR_LSB +: CNT_W]    = cfg.sample;
                rdata[F_PAGE_LSB +: PAGE_W] = cfg.page;
            end
        endcase
    end

endmodule

// File: rtl/emc_cycle_seq.sv
module emc_cycle_seq
    import emc_strobe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  timing_cfg_t      cfg,
    output logic             req_ready,
    output logic             busy,
    output logic             run_nxt,
    output logic [CNT_W-1:0] cnt_nxt,
    output cycle_cfg_t       cyc_nxt
);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    cycle_cfg_t       cyc_q;
    logic             accept;
    logic             at_last;

    // Pick the deassert ticks and length for the requested cycle type.
    function automatic cycle_cfg_t resolve(input timing_cfg_t c, input logic wr);
        cycle_cfg_t       r;
        logic [CNT_W-1:0] len;
        r = '0;
        r.write             = wr;
        r.on_tick[STB_CS]   = CNT_W'(c.cs_on);
        r.off_tick[STB_CS]  = wr ? c.cs_wr_off : c.cs_rd_off;
        r.on_tick[STB_ADV]  = CNT_W'(c.adv_on);
        r.off_tick[STB_ADV] = wr ? c.adv_wr_off : c.adv_rd_off;
        r.on_tick[STB_OE]   = CNT_W'(c.oe_on);
        r.off_tick[STB_OE]  = c.oe_off;
        r.on_tick[STB_WE]   = CNT_W'(c.we_on);
        r.off_tick[STB_WE]  = c.we_off;
        r.sample            = c.sample;
        len                 = wr ? c.wr_len : c.rd_len;
        r.last_tick         = (len == '0) ? '0 : CNT_W'(len - 1'b1);
        return r;
    endfunction

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign at_last = (state_q == ST_RUN) && (cnt_q == cyc_q.last_tick);

    // Transitions: LAUNCH (IDLE->RUN), STEP (RUN->RUN), FINISH (RUN->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)  state_d = ST_RUN;
            ST_RUN:  if (at_last) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next tick count and cycle snapshot
    always_comb begin
        cnt_nxt = cnt_q;
        cyc_nxt = cyc_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    cnt_nxt = '0;
                    cyc_nxt = resolve(cfg, req_write);
                end
            end
            ST_RUN: begin
                if (!at_last) cnt_nxt = CNT_W'(cnt_q + 1'b1);
            end
        endcase
        run_nxt = (state_d == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cyc_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            cyc_q <= cyc_nxt;
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign busy      = (state_q == ST_RUN);

    // R3
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid) |=> (state_q == ST_RUN && cnt_q == '0));

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q <= cyc_q.last_tick));

    // R9
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cnt_q != '0) |-> $stable(cyc_q));

endmodule

// File: rtl/emc_strobe_gen.sv
module emc_strobe_gen
    import emc_strobe_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run_nxt,
    input  logic [CNT_W-1:0]       cnt_nxt,
    input  cycle_cfg_t             cyc_nxt,
    output logic [NUM_STROBES-1:0] strobe_n,
    output logic                   rd_capture
);

    logic [NUM_STROBES-1:0] act_d;
    logic                   cap_d;
    logic                   wr_q;

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_stb
        localparam bit READ_OK  = (g != STB_WE);
        localparam bit WRITE_OK = (g != STB_OE);
        logic allow;
        assign allow    = cyc_nxt.write ? WRITE_OK : READ_OK;
        assign act_d[g] = run_nxt && allow &&
                          (cnt_nxt >= cyc_nxt.on_tick[g]) &&
                          (cnt_nxt <  cyc_nxt.off_tick[g]);
    end

    assign cap_d = run_nxt && !cyc_nxt.write && (cnt_nxt == cyc_nxt.sample);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_n   <= '1;
            rd_capture <= 1'b0;
            wr_q       <= 1'b0;
        end else begin
            strobe_n   <= ~act_d;
            rd_capture <= cap_d;
            wr_q       <= run_nxt && cyc_nxt.write;
        end
    end

    // R5
    oe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |-> strobe_n[STB_OE]);

    // R5
    we_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_q |-> strobe_n[STB_WE]);

endmodule

// File: rtl/emc_strobe_seq.sv
module emc_strobe_seq
    import emc_strobe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [1:0]  cfg_idx,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        req_valid,
    input  logic        req_write,
    output logic        req_ready,
    output logic        busy,
    output logic        cs_n,
    output logic        adv_n,
    output logic        oe_n,
    output logic        we_n,
    output logic        rd_capture
);

    timing_cfg_t            cfg;
    logic                   run_nxt;
    logic [CNT_W-1:0]       cnt_nxt;
    cycle_cfg_t             cyc_nxt;
    logic [NUM_STROBES-1:0] strobe_n;

    emc_timing_regs regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    emc_cycle_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .cfg       (cfg),
        .req_ready (req_ready),
        .busy      (busy),
        .run_nxt   (run_nxt),
        .cnt_nxt   (cnt_nxt),
        .cyc_nxt   (cyc_nxt)
    );

    emc_strobe_gen gen_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_nxt    (run_nxt),
        .cnt_nxt    (cnt_nxt),
        .cyc_nxt    (cyc_nxt),
        .strobe_n   (strobe_n),
        .rd_capture (rd_capture)
    );

    assign cs_n  = strobe_n[STB_CS];
    assign adv_n = strobe_n[STB_ADV];
    assign oe_n  = strobe_n[STB_OE];
    assign we_n  = strobe_n[STB_WE];

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && adv_n && oe_n && we_n && !rd_capture));

    // R6
    capture_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_capture |-> (busy && we_n));

endmodule

// File: tb/emc_strobe_seq_tb.sv
module emc_strobe_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_ready, busy, cs_n, adv_n, oe_n, we_n, rd_capture;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // bench model of the programmed fields
    int m_cs_on, m_cs_rd, m_cs_wr, m_adv_on, m_adv_rd, m_adv_wr;
    int m_oe_on, m_oe_off, m_we_on, m_we_off, m_rd_len, m_wr_len, m_smp, m_page;

    always #(CLK_PERIOD/2) clk = ~clk;

    emc_strobe_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_write(req_write), .req_ready(req_ready), .busy(busy), .cs_n(cs_n),
        .adv_n(adv_n), .oe_n(oe_n), .we_n(we_n), .rd_capture(rd_capture)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void model_update(input int idx, input logic [31:0] d);
        case (idx)
            0: begin m_cs_on = int'(d[3:0]); m_cs_rd = int'(d[12:8]); m_cs_wr = int'(d[20:16]); end
            1: begin m_adv_on = int'(d[3:0]); m_adv_rd = int'(d[12:8]); m_adv_wr = int'(d[20:16]); end
            2: begin m_oe_on = int'(d[3:0]); m_oe_off = int'(d[12:8]);
                     m_we_on = int'(d[19:16]); m_we_off = int'(d[28:24]); end
            default: begin m_rd_len = int'(d[4:0]); m_wr_len = int'(d[12:8]);
                           m_smp = int'(d[20:16]); m_page = int'(d[27:24]); end
        endcase
    endfunction

    function automatic logic [31:0] exp_word(input int idx);
        case (idx)
            0: return 32'(m_cs_on) | (32'(m_cs_rd) << 8) | (32'(m_cs_wr) << 16);
            1: return 32'(m_adv_on) | (32'(m_adv_rd) << 8) | (32'(m_adv_wr) << 16);
            2: return 32'(m_oe_on) | (32'(m_oe_off) << 8) | (32'(m_we_on) << 16) | (32'(m_we_off) << 24);
            default: return 32'(m_rd_len) | (32'(m_wr_len) << 8) | (32'(m_smp) << 16) | (32'(m_page) << 24);
        endcase
    endfunction

    function automatic logic [31:0] mk3(input int a, input int b, input int c, input int d);
        return 32'(a) | (32'(b) << 8) | (32'(c) << 16) | (32'(d) << 24);
    endfunction

    function automatic logic win_n(input int k, input int on, input int off);
        return !(k >= on && k < off);
    endfunction

    task automatic cfg_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_idx = 2'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        model_update(idx, d);
    endtask

    task automatic rd_check(input string req, input int idx);
        @(negedge clk);
        cfg_idx = 2'(idx);
        #1;
        chk(req, "cfg_rdata", cfg_rdata, exp_word(idx));
    endtask

    task automatic launch(input bit wr, input bit hold);
        @(negedge clk);
        chk("R8", "req_ready before launch", req_ready, 1'b1);
        req_valid = 1'b1; req_write = wr;
        @(negedge clk);
        if (!hold) req_valid = 1'b0;
    endtask

    // Called at the negedge holding tick 0 of a cycle.
    task automatic check_ticks(input bit wr, input bit mid, input int mid_idx,
                               input logic [31:0] mid_data);
        int con  = m_cs_on,  coff = wr ? m_cs_wr  : m_cs_rd;
        int aon  = m_adv_on, aoff = wr ? m_adv_wr : m_adv_rd;
        int oon  = m_oe_on,  ooff = m_oe_off;
        int won  = m_we_on,  woff = m_we_off;
        int smp  = m_smp;
        int len  = wr ? m_wr_len : m_rd_len;
        if (len == 0) len = 1;
        for (int k = 0; k < len; k++) begin
            chk("R4", $sformatf("cs_n t%0d", k),  cs_n,  win_n(k, con, coff));
            chk("R4", $sformatf("adv_n t%0d", k), adv_n, win_n(k, aon, aoff));
            chk("R5", $sformatf("oe_n t%0d", k),  oe_n,  wr ? 1'b1 : win_n(k, oon, ooff));
            chk("R5", $sformatf("we_n t%0d", k),  we_n,  wr ? win_n(k, won, woff) : 1'b1);
            chk("R6", $sformatf("rd_capture t%0d", k), rd_capture, (!wr && k == smp));
            chk("R7", $sformatf("busy t%0d", k), busy, 1'b1);
            chk("R8", $sformatf("req_ready t%0d", k), req_ready, 1'b0);
            if (mid && k == 1) begin
                cfg_wr_en = 1'b1; cfg_idx = 2'(mid_idx); cfg_wdata = mid_data;
            end
            if (mid && k == 2) begin
                cfg_wr_en = 1'b0;
                model_update(mid_idx, mid_data);
            end
            @(negedge clk);
        end
        chk("R7", "busy after end", busy, 1'b0);
        chk("R8", "req_ready after end", req_ready, 1'b1);
        chk("R7", "strobes after end", {cs_n, adv_n, oe_n, we_n, rd_capture}, 5'b11110);
    endtask

    task automatic program_all(input logic [31:0] w0, input logic [31:0] w1,
                               input logic [31:0] w2, input logic [31:0] w3);
        cfg_write(0, w0); cfg_write(1, w1); cfg_write(2, w2); cfg_write(3, w3);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd7341);
        model_update(0, '0); model_update(1, '0); model_update(2, '0); model_update(3, '0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "strobes", {cs_n, adv_n, oe_n, we_n}, 4'hF);
        chk("R1", "rd_capture", rd_capture, 1'b0);
        chk("R1", "busy", busy, 1'b0);
        chk("R1", "req_ready", req_ready, 1'b1);
        for (int i = 0; i < 4; i++) rd_check("R1", i);

        // R2 field layout and unused bits
        for (int i = 0; i < 4; i++) begin
            cfg_write(i, 32'hFFFF_FFFF);
            rd_check("R2", i);
        end
        chk("R2", "enables mask", exp_word(2), 32'h1F0F_1F0F);
        chk("R2", "cycle mask", exp_word(3), 32'h0F1F_1F1F);

        // R3 R4 R5 R6 basic read, then write
        program_all(mk3(1, 9, 7, 0), mk3(0, 3, 2, 0), mk3(3, 8, 2, 6), mk3(10, 8, 7, 0));
        launch(1'b0, 1'b0); check_ticks(1'b0, 1'b0, 0, '0);
        launch(1'b1, 1'b0); check_ticks(1'b1, 1'b0, 0, '0);

        // R10 inverted windows
        program_all(mk3(6, 4, 2, 0), mk3(5, 5, 5, 0), mk3(9, 2, 7, 7), mk3(8, 8, 3, 0));
        launch(1'b0, 1'b0); check_ticks(1'b0, 1'b0, 0, '0);
        launch(1'b1, 1'b0); check_ticks(1'b1, 1'b0, 0, '0);

        // R6 sampling tick beyond cycle length
        program_all(mk3(0, 31, 31, 0), mk3(0, 2, 2, 0), mk3(0, 31, 0, 31), mk3(8, 6, 20, 0));
        launch(1'b0, 1'b0); check_ticks(1'b0, 1'b0, 0, '0);

        // R7 length 0 and 1
        cfg_write(3, mk3(0, 1, 0, 0));
        launch(1'b0, 1'b0); check_ticks(1'b0, 1'b0, 0, '0);
        launch(1'b1, 1'b0); check_ticks(1'b1, 1'b0, 0, '0);

        // R8 held request restarts after one idle tick
        program_all(mk3(1, 4, 5, 0), mk3(0, 2, 3, 0), mk3(1, 4, 1, 5), mk3(5, 6, 3, 0));
        launch(1'b0, 1'b1);
        req_write = 1'b1;
        check_ticks(1'b0, 1'b0, 0, '0);
        @(negedge clk);
        req_valid = 1'b0;
        check_ticks(1'b1, 1'b0, 0, '0);

        // R9 write during a cycle applies to the next one
        cfg_write(3, mk3(10, 10, 2, 0));
        launch(1'b0, 1'b0);
        check_ticks(1'b0, 1'b1, 3, mk3(4, 4, 1, 0));
        chk("R9", "new length programmed", m_rd_len, 4);
        launch(1'b0, 1'b0); check_ticks(1'b0, 1'b0, 0, '0);

        // random cycles
        for (int n = 0; n < 40; n++) begin
            program_all($urandom, $urandom, $urandom, $urandom);
            launch(1'($urandom), 1'b0);
            check_ticks(req_write, 1'b0, 0, '0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule